// File: doc/BRIEF.md
# Predicated vector element sequencer

This block walks the elements of one vector operation, in ascending index order, under a per-element predicate mask. Each element it visits gets the sum of two source operands, read from a local operand array at the same index, written into a destination element array. When zeroing is off, elements whose predicate bit is clear are skipped: the ALU does not see them and the destination keeps its old value. When zeroing is on, those elements are written with zero instead. The predicate mask and the zeroing flag both belong to the destination operand, so one setting covers the whole operation.

A start strobe captures the vector length, the mask and the zeroing flag. The sequencer then produces one destination write per cycle, each visible on a write-enable, index and data triple. It ends with a single-cycle done pulse. A load port fills the operand arrays and presets the destination, and a combinational read port returns any destination element.

Top module: `vec_pred_seq`

## Requirements
- R1: After reset, busy_o, done_o and wr_en_o are low and every destination element reads back as zero.
- R2: Destination writes of one operation come out in strictly ascending element index order, and no more than one write happens per cycle.
- R3: An element whose predicate bit is set is written with the 32-bit wrapping sum of its operand A and operand B, whether zeroing is on or off.
- R4: With zeroing on, an element below the vector length whose predicate bit is clear is written with zero.
- R5: With zeroing off, an element whose predicate bit is clear is never written and keeps its old value. The sequencer moves straight to the next set bit, so an operation takes exactly one write cycle per set bit below the vector length.
- R6: An element whose index is equal to or above the vector length vlen_i (0 to 15) is never written. Predicate bit i governs element i.
- R7: busy_o is high from the clock edge that accepts a start through the cycle of the last write. done_o is high for exactly the one cycle after that.
- R8: If a start is accepted with nothing to write (vlen_i of 0, or zeroing off with no set predicate bit below the length), done_o is high in the cycle right after the start edge, busy_o stays low, and nothing is written.
- R9: start_i is ignored while busy_o is high. The length, mask and zeroing flag are captured at the accepted start, and later changes to these inputs have no effect on the running operation.
- R10: The load port writes ld_data_i at ld_idx_i into operand A (ld_sel_i = 0), operand B (1) or the destination (2). Code 3 writes nothing. rd_data_o returns the destination element at rd_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when idle |
| vlen_i | input | 4 | Vector length, 0 to 15 |
| pmask_i | input | 16 | Destination predicate mask, bit i for element i |
| zero_en_i | input | 1 | Destination zeroing flag |
| ld_we_i | input | 1 | Load port write enable |
| ld_sel_i | input | 2 | Load target: 0 operand A, 1 operand B, 2 destination, 3 none |
| ld_idx_i | input | 4 | Load element index |
| ld_data_i | input | 32 | Load data |
| rd_idx_i | input | 4 | Destination read index |
| rd_data_o | output | 32 | Destination element at rd_idx_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wr_en_o | output | 1 | Destination write this cycle |
| wr_idx_o | output | 4 | Destination write index |
| wr_data_o | output | 32 | Destination write data |

## Verification
The destination is preset with non-zero values before each operation, so a skipped element and an element written with zero can be told apart. Directed patterns cover a zero length, an empty mask with and without zeroing, masks with leading, trailing and interior runs of clear bits, a full mask at maximum length with bit 15 set, and an add that wraps. Random masks, lengths and zeroing flags follow, and the inputs are changed after each start. A few operations also receive a second start while busy, which separates latching and start filtering from a sequencer that follows its live inputs. The write sequence is compared cycle by cycle with a list built from the requirements, which checks the order, the count that skipping implies, the done timing and the final destination contents.

// File: rtl/vps_pkg.sv
package vps_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vps_state_e;

  localparam logic [1:0] LD_SEL_A   = 2'd0;
  localparam logic [1:0] LD_SEL_B   = 2'd1;
  localparam logic [1:0] LD_SEL_DST = 2'd2;
endpackage

// File: rtl/vps_lsb_find.sv
module vps_lsb_find #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // scan high to low so the lowest set bit is the last assignment
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vps_operand_rf.sv
module vps_operand_rf #(
  parameter int NUM_ELEM = 16,
  parameter int ELEM_W   = 32,
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_a_i,
  input  logic              we_b_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ELEM_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ELEM_W-1:0] a_o,
  output logic [ELEM_W-1:0] b_o
);
  logic [ELEM_W-1:0] a_q [NUM_ELEM];
  logic [ELEM_W-1:0] b_q [NUM_ELEM];

  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q[g] <= '0;
        b_q[g] <= '0;
      end else if (wr_idx_i == IDX_W'(g)) begin
        if (we_a_i) a_q[g] <= wr_data_i;
        if (we_b_i) b_q[g] <= wr_data_i;
      end
    end
  end

  assign a_o = a_q[rd_idx_i];
  assign b_o = b_q[rd_idx_i];
endmodule

// File: rtl/vps_dest_rf.sv
module vps_dest_rf #(
  parameter int NUM_ELEM = 16,
  parameter int ELEM_W   = 32,
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seq_we_i,
  input  logic [IDX_W-1:0]  seq_idx_i,
  input  logic [ELEM_W-1:0] seq_data_i,
  input  logic              ld_we_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [ELEM_W-1:0] ld_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ELEM_W-1:0] rd_data_o
);
  logic [ELEM_W-1:0] mem_q [NUM_ELEM];

  // sequencer write wins over a load to the same element
  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (seq_we_i && seq_idx_i == IDX_W'(g)) begin
        mem_q[g] <= seq_data_i;
      end else if (ld_we_i && ld_idx_i == IDX_W'(g)) begin
        mem_q[g] <= ld_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/vec_pred_seq.sv
module vec_pred_seq
  import vps_pkg::*;
#(
  parameter int NUM_ELEM = 16,
  parameter int ELEM_W   = 32,
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [IDX_W-1:0]    vlen_i,
  input  logic [NUM_ELEM-1:0] pmask_i,
  input  logic                zero_en_i,
  input  logic                ld_we_i,
  input  logic [1:0]          ld_sel_i,
  input  logic [IDX_W-1:0]    ld_idx_i,
  input  logic [ELEM_W-1:0]   ld_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [ELEM_W-1:0]   rd_data_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [ELEM_W-1:0]   wr_data_o
);
  vps_state_e          state_q;
  logic [NUM_ELEM-1:0] mask_q;
  logic [NUM_ELEM-1:0] pend_q;
  logic [NUM_ELEM-1:0] pend_nxt;
  logic [NUM_ELEM-1:0] elig;
  logic [NUM_ELEM-1:0] hit_oh;
  logic                done_q;
  logic                start_ok;
  logic                hit;
  logic [IDX_W-1:0]    hit_idx;
  logic [ELEM_W-1:0]   op_a;
  logic [ELEM_W-1:0]   op_b;
  logic [ELEM_W-1:0]   sum;

  // elements to visit: below VL, and either predicated-in or zeroing on
  for (genvar g = 0; g < NUM_ELEM; g++) begin : g_elig
    assign elig[g] = (IDX_W'(g) < vlen_i) && (zero_en_i || pmask_i[g]);
  end

  assign start_ok = start_i && (state_q == ST_IDLE);

  vps_lsb_find #(.N(NUM_ELEM), .IDX_W(IDX_W)) u_find (
    .vec_i   (pend_q),
    .found_o (hit),
    .idx_o   (hit_idx)
  );

  assign hit_oh   = NUM_ELEM'(1) << hit_idx;
  assign pend_nxt = pend_q & ~hit_oh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      pend_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        mask_q  <= pmask_i;
        pend_q  <= elig;
        state_q <= (|elig) ? ST_RUN : ST_IDLE;
        done_q  <= ~|elig;
      end else if (state_q == ST_RUN) begin
        pend_q <= pend_nxt;
        if (pend_nxt == '0) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  vps_operand_rf #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .IDX_W(IDX_W)) u_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_a_i    (ld_we_i && ld_sel_i == LD_SEL_A),
    .we_b_i    (ld_we_i && ld_sel_i == LD_SEL_B),
    .wr_idx_i  (ld_idx_i),
    .wr_data_i (ld_data_i),
    .rd_idx_i  (hit_idx),
    .a_o       (op_a),
    .b_o       (op_b)
  );

  assign sum       = op_a + op_b;
  assign wr_en_o   = (state_q == ST_RUN) && hit;
  assign wr_idx_o  = hit_idx;
  assign wr_data_o = mask_q[hit_idx] ? sum : '0;

  vps_dest_rf #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .IDX_W(IDX_W)) u_dst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .seq_we_i   (wr_en_o),
    .seq_idx_i  (wr_idx_o),
    .seq_data_i (wr_data_o),
    .ld_we_i    (ld_we_i && ld_sel_i == LD_SEL_DST),
    .ld_idx_i   (ld_idx_i),
    .ld_data_i  (ld_data_i),
    .rd_idx_i   (rd_idx_i),
    .rd_data_o  (rd_data_o)
  );

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/vps_chk.sv
module vps_chk #(
  parameter int NUM_ELEM = 16,
  parameter int ELEM_W   = 32,
  parameter int IDX_W    = $clog2(NUM_ELEM)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [IDX_W-1:0]    vlen_i,
  input logic [NUM_ELEM-1:0] pmask_i,
  input logic                zero_en_i,
  input logic                busy_o,
  input logic                done_o,
  input logic                wr_en_o,
  input logic [IDX_W-1:0]    wr_idx_o,
  input logic [ELEM_W-1:0]   wr_data_o,
  input logic [NUM_ELEM-1:0] mask_q
);
  // checker's own copy of the operation settings, taken at ports
  logic [IDX_W-1:0]    vl_c;
  logic [NUM_ELEM-1:0] mask_c;
  logic                zero_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_c   <= '0;
      mask_c <= '0;
      zero_c <= 1'b0;
    end else if (start_i && !busy_o) begin
      vl_c   <= vlen_i;
      mask_c <= pmask_i;
      zero_c <= zero_en_i;
    end
  end

  assert_wr_in_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);

  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_below_vl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_idx_o < vl_c));

  assert_skip_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !zero_c) |-> mask_c[wr_idx_o]);

  assert_zero_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !mask_c[wr_idx_o]) |-> (wr_data_o == '0));

  assert_ascending_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (wr_idx_o > $past(wr_idx_o)));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(mask_q));
endmodule

bind vec_pred_seq vps_chk #(
  .NUM_ELEM (NUM_ELEM),
  .ELEM_W   (ELEM_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .vlen_i    (vlen_i),
  .pmask_i   (pmask_i),
  .zero_en_i (zero_en_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .wr_en_o   (wr_en_o),
  .wr_idx_o  (wr_idx_o),
  .wr_data_o (wr_data_o),
  .mask_q    (mask_q)
);

// File: tb/vec_pred_seq_bench.sv
module vec_pred_seq_bench;
  localparam int N = 16;
  localparam int W = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [IW-1:0] vlen_i = '0;
  logic [N-1:0]  pmask_i = '0;
  logic          zero_en_i = 1'b0;
  logic          ld_we_i = 1'b0;
  logic [1:0]    ld_sel_i = '0;
  logic [IW-1:0] ld_idx_i = '0;
  logic [W-1:0]  ld_data_i = '0;
  logic [IW-1:0] rd_idx_i = '0;
  logic [W-1:0]  rd_data_o;
  logic          busy_o, done_o, wr_en_o;
  logic [IW-1:0] wr_idx_o;
  logic [W-1:0]  wr_data_o;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] ma [N];
  logic [W-1:0] mb [N];
  logic [W-1:0] md [N];

  always #4 clk = ~clk;

  vec_pred_seq u_vec_pred_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .vlen_i(vlen_i),
    .pmask_i(pmask_i), .zero_en_i(zero_en_i), .ld_we_i(ld_we_i),
    .ld_sel_i(ld_sel_i), .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o), .busy_o(busy_o),
    .done_o(done_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
    .wr_data_o(wr_data_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_val(input int i, input logic [N-1:0] m);
    return m[i] ? ma[i] + mb[i] : '0;
  endfunction

  task automatic load(input logic [1:0] sel, input int idx, input logic [W-1:0] d);
    @(negedge clk);
    ld_we_i = 1'b1; ld_sel_i = sel; ld_idx_i = IW'(idx); ld_data_i = d;
    @(negedge clk);
    ld_we_i = 1'b0;
    case (sel)
      2'd0: ma[idx] = d;
      2'd1: mb[idx] = d;
      2'd2: md[idx] = d;
      default: ;
    endcase
  endtask

  task automatic readback(input string req);
    for (int i = 0; i < N; i++) begin
      rd_idx_i = IW'(i);
      #1;
      chk(rd_data_o == md[i], req, $sformatf("dest[%0d]", i), rd_data_o, md[i]);
    end
  endtask

  task automatic run_op(input int vl, input logic [N-1:0] m, input bit z,
                        input bit poke);
    int exp_idx [N];
    int k = 0;
    for (int i = 0; i < N; i++)
      if (i < vl && (z || m[i])) begin exp_idx[k] = i; k++; end
    @(negedge clk);
    start_i = 1'b1; vlen_i = IW'(vl); pmask_i = m; zero_en_i = z;
    @(negedge clk);
    start_i = 1'b0;
    // R9: settings were latched; scramble the live inputs
    vlen_i = IW'($urandom); pmask_i = N'($urandom); zero_en_i = ~z;
    for (int j = 0; j < k; j++) begin
      chk(wr_en_o === 1'b1, "R5", "write slot", W'(wr_en_o), 1);
      chk(busy_o === 1'b1, "R7", "busy", W'(busy_o), 1);
      chk(wr_idx_o == IW'(exp_idx[j]), "R2", "write index", W'(wr_idx_o),
          W'(exp_idx[j]));
      chk(wr_data_o == exp_val(exp_idx[j], m),
          m[exp_idx[j]] ? "R3" : "R4", "write data", wr_data_o,
          exp_val(exp_idx[j], m));
      md[exp_idx[j]] = exp_val(exp_idx[j], m);
      start_i = 1'b0;
      if (poke && j == 0) begin
        start_i = 1'b1; vlen_i = 4'd15; pmask_i = '1; zero_en_i = 1'b1;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(wr_en_o === 1'b0, k == 0 ? "R8" : "R5", "extra write", W'(wr_en_o), 0);
    chk(done_o === 1'b1, k == 0 ? "R8" : "R7", "done", W'(done_o), 1);
    chk(busy_o === 1'b0, "R7", "busy after", W'(busy_o), 0);
    @(negedge clk);
    chk(done_o === 1'b0, "R7", "done width", W'(done_o), 0);
    chk(wr_en_o === 1'b0, "R9", "write after done", W'(wr_en_o), 0);
    readback(poke ? "R9" : (z ? "R4" : "R6"));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin ma[i] = '0; mb[i] = '0; md[i] = '0; end
    #20;
    #1 chk(busy_o === 1'b0 && done_o === 1'b0 && wr_en_o === 1'b0, "R1",
           "reset outputs", {busy_o, done_o, wr_en_o}, 0);
    rst_n = 1'b1;
    readback("R1");

    // R10: load every array, code 3 must write nothing
    for (int i = 0; i < N; i++) begin
      load(2'd0, i, $urandom);
      load(2'd1, i, $urandom);
      load(2'd2, i, 32'hD000_0000 | i);
    end
    load(2'd3, 5, 32'h1234_5678);
    readback("R10");

    load(2'd0, 2, 32'hFFFF_FFFF);
    load(2'd1, 2, 32'h0000_0001);        // R3 wrap to zero

    run_op(0, '1, 1'b1, 1'b0);           // R8 zero length
    run_op(9, '0, 1'b0, 1'b0);           // R8 empty mask, no zeroing
    run_op(5, '0, 1'b1, 1'b0);           // R4 all zero writes
    for (int i = 0; i < N; i++) load(2'd2, i, 32'hC000_0000 | i);
    run_op(12, 16'h0A14, 1'b0, 1'b0);    // R5 runs of clear bits
    run_op(15, '1, 1'b0, 1'b0);          // R6 bit 15 never written
    run_op(10, 16'h8304, 1'b1, 1'b0);    // R4 and R6 mix
    run_op(8, 16'h00FF, 1'b1, 1'b1);     // R9 start while busy
    run_op(3, 16'h0004, 1'b0, 1'b0);     // R3 wrapping add at element 2

    for (int t = 0; t < 40; t++) begin
      if (t % 4 == 0)
        for (int i = 0; i < N; i++) begin
          load(2'd0, i, $urandom);
          load(2'd1, i, $urandom);
          load(2'd2, i, $urandom);
        end
      run_op(int'($urandom_range(15, 0)), N'($urandom), 1'($urandom),
             (t % 5) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule